// File: doc/BRIEF.md
# Serial Flash Command Guard

This block decides which modifying commands a 64-sector, 128 Mbit serial flash may run. An SPI front end has already decoded each instruction. It hands over one event per chip-select frame, carrying the opcode, the 24-bit address, the count of clock pulses seen while select was low, and the status data byte. The guard checks the event against its own state and returns one accept or reject decision. Its state is the write-enable latch, a write-in-progress flag, a three-bit protection level and a status-lock bit.

Command events come in on a valid/ready pair. Decisions go out on a one-entry valid/ready output register. The upstream may hold `cmd_valid` with stable fields for as long as it likes. An event is consumed on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high exactly when the output register is empty or is being drained in that cycle. A decision stays on `dec_valid`/`dec_accept`/`dec_opcode`, unchanged, until `dec_ready` takes it. The array controller sends a single-cycle `op_done` pulse when a program or erase ends. The write-protect pin and the status byte are plain signals.

A power-on lockout counter blocks every modifying command for a fixed number of clock cycles after reset.

Top module: `flash_guard`

## Requirements
- R1: The sector index is address bits [23:18]. A program (0x02) or sector erase (0xD8) is rejected when that sector is inside the protected region. The protected region follows the 3-bit level as follows. Level 0: no sectors. Level 1: sector 63. Level 2: sectors 62-63. Level 3: sectors 60-63. Level 4: sectors 56-63. Level 5: sectors 48-63. Level 6: sectors 32-63. Level 7: every sector.
- R2: A bulk erase (0xC7) is accepted only when the protection level is 0.
- R3: Program, sector erase, bulk erase and status write (0x01) are rejected unless the clock-pulse count is a multiple of eight.
- R4: A modifying command is rejected while the write-enable latch is clear. Write enable (0x06) sets the latch.
- R5: The latch is cleared by reset, by write disable (0x04), by an accepted status write, and by the `op_done` pulse that ends an accepted program or erase.
- R6: While the status-lock bit is 1 and `wp_n` is low, a status write is rejected and neither the lock bit nor the protection level changes.
- R7: For LOCK_CYC cycles after reset, every modifying command is rejected.
- R8: A rejected command changes neither the latch nor any status bit.
- R9: The status byte is laid out as bit7 = lock, bits4:2 = protection level, bit1 = write-enable latch, bit0 = write in progress, with bits 6:5 always 0. A status write copies data bits 7 and 4:2 only. Reset clears the whole byte.
- R10: An accepted program or erase sets the in-progress bit until `op_done`. While the bit is set, every command, including write enable and write disable, is rejected.
- R11: A decision is held, unchanged, until `dec_ready`. `cmd_ready` is low while an undrained decision is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | Command event present |
| cmd_ready | output | 1 | Guard can take a command event |
| cmd_opcode | input | 8 | Decoded instruction opcode |
| cmd_addr | input | ADDR_W | Byte address from the frame |
| cmd_clk_cnt | input | CNT_W | Clock pulses counted while select was low |
| cmd_wdata | input | 8 | Data byte for a status write |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Downstream takes the decision |
| dec_accept | output | 1 | 1 = command accepted, 0 = rejected |
| dec_opcode | output | 8 | Opcode the decision belongs to |
| op_done | input | 1 | One-cycle pulse: program or erase finished |
| status_o | output | 8 | Status byte |

## Verification
Any state in the guard becomes visible at the ports one cycle after the event that changes it. A latch, level or lock bit with a wrong value shows up at once on `status_o`. It also shows up in the next decision that depends on it, for example a program accepted into a protected sector or a status write that gets through a hardware lock. A lockout counter of the wrong length can only be seen by a modifying command sent near the end of the window. A wrong in-progress flag shows up as a write enable being accepted or rejected when it should not be, before `op_done` arrives.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE
  } cmd_kind_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] zero;
    logic [2:0] level;
    logic       wel;
    logic       wip;
  } status_t;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      OPC_WREN: return K_WREN;
      OPC_WRDI: return K_WRDI;
      OPC_WRSR: return K_WRSR;
      OPC_PP:   return K_PP;
      OPC_SE:   return K_SE;
      OPC_BE:   return K_BE;
      default:  return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wp_por_lockout.sv
module wp_por_lockout #(
  parameter int LOCK_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYC + 2);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign locked = (cnt != LIMIT);
endmodule

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
  parameter int SECT_W = 6
) (
  input  logic [2:0]        level,
  input  logic [SECT_W-1:0] sector,
  output logic              hit,
  output logic              any
);
  localparam int NSECT = 1 << SECT_W;
  localparam logic [SECT_W:0] NSECT_V = (SECT_W+1)'(NSECT);

  logic [SECT_W:0]  span;
  logic [SECT_W:0]  first;
  logic [NSECT-1:0] mask;

  // protected sectors grow from the top: 1, 2, 4 ... all
  always_comb begin
    if (level == 3'd0) span = '0;
    else               span = (SECT_W+1)'(NSECT >> (7 - int'(level)));
    first = NSECT_V - span;
  end

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    assign mask[s] = ((SECT_W+1)'(s) >= first) && (span != '0);
  end

  assign hit = mask[sector];
  assign any = (level != 3'd0);
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import flash_wp_pkg::*;
(
  input  logic [7:0] op,
  input  logic       frame_ok,
  input  logic       wel,
  input  logic       wip,
  input  logic       locked,
  input  logic       level_any,
  input  logic       sect_hit,
  input  logic       hw_lock,
  output cmd_kind_e  kind,
  output logic       accept
);
  logic base_ok;

  always_comb begin
    kind    = classify(op);
    base_ok = !wip && !locked && frame_ok && wel;
    case (kind)
      K_WREN, K_WRDI: accept = !wip;
      K_PP, K_SE:     accept = base_ok && !sect_hit;
      K_BE:           accept = base_ok && !level_any;
      K_WRSR:         accept = base_ok && !hw_lock;
      default:        accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_W   = 6,
  parameter int CNT_W    = 16,
  parameter int LOCK_CYC = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_clk_cnt,
  input  logic [7:0]        cmd_wdata,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  output logic [7:0]        dec_opcode,
  input  logic              op_done,
  output logic [7:0]        status_o
);
  localparam int LOW_W = ADDR_W - SECT_W;

  logic       wel, wip, lock;
  logic [2:0] level;
  logic       locked, sect_hit, level_any, accept, fire;
  cmd_kind_e  kind;
  status_t    st;

  logic unused_bits;
  assign unused_bits = ^{cmd_addr[LOW_W-1:0], cmd_clk_cnt[CNT_W-1:3],
                         cmd_wdata[6:5], cmd_wdata[1:0]};

  wp_por_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
    .clk(clk), .rst_n(por_n), .locked(locked)
  );

  wp_region_decode #(.SECT_W(SECT_W)) u_region (
    .level(level), .sector(cmd_addr[ADDR_W-1 -: SECT_W]),
    .hit(sect_hit), .any(level_any)
  );

  wp_cmd_gate u_gate (
    .op(cmd_opcode), .frame_ok(cmd_clk_cnt[2:0] == 3'd0),
    .wel(wel), .wip(wip), .locked(locked), .level_any(level_any),
    .sect_hit(sect_hit), .hw_lock(lock && !wp_n),
    .kind(kind), .accept(accept)
  );

  assign cmd_ready = !dec_valid || dec_ready;
  assign fire      = cmd_valid && cmd_ready;

  // decision register
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_opcode <= '0;
    end else if (fire) begin
      dec_valid  <= 1'b1;
      dec_accept <= accept;
      dec_opcode <= cmd_opcode;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end

  // protection and latch state
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wel   <= 1'b0;
      wip   <= 1'b0;
      lock  <= 1'b0;
      level <= '0;
    end else begin
      if (op_done && wip) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
      if (fire && accept) begin
        case (kind)
          K_WREN: wel <= 1'b1;
          K_WRDI: wel <= 1'b0;
          K_WRSR: begin
            lock  <= cmd_wdata[7];
            level <= cmd_wdata[4:2];
            wel   <= 1'b0;
          end
          K_PP, K_SE, K_BE: wip <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    st.lock  = lock;
    st.zero  = 2'b00;
    st.level = level;
    st.wel   = wel;
    st.wip   = wip;
  end
  assign status_o = st;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int LOCK_CYC = 32
) (
  input logic       clk,
  input logic       por_n,
  input logic       wp_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_opcode,
  input logic [2:0] cnt_lo,
  input logic       dec_valid,
  input logic       dec_ready,
  input logic       dec_accept,
  input logic [7:0] status_o
);
  logic fire, modify;
  int   since;

  assign fire   = cmd_valid && cmd_ready;
  assign modify = (cmd_opcode == 8'h01) || (cmd_opcode == 8'h02) ||
                  (cmd_opcode == 8'hD8) || (cmd_opcode == 8'hC7);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                since <= 0;
    else if (since < LOCK_CYC) since <= since + 1;
  end

  AST_DEC_HELD: assert property (@(posedge clk) disable iff (!por_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_accept)); // R11
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    dec_valid && !dec_ready |-> !cmd_ready); // R11
  AST_BULK_LEVEL: assert property (@(posedge clk) disable iff (!por_n)
    fire && cmd_opcode == 8'hC7 && status_o[4:2] != 3'd0 |=> !dec_accept); // R2
  AST_FRAME_BAD: assert property (@(posedge clk) disable iff (!por_n)
    fire && modify && cnt_lo != 3'd0 |=> !dec_accept); // R3
  AST_NEED_WEL: assert property (@(posedge clk) disable iff (!por_n)
    fire && modify && !status_o[1] |=> !dec_accept); // R4
  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    fire && cmd_opcode == 8'h04 && !status_o[0] |=> !status_o[1]); // R5
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    fire && cmd_opcode == 8'h01 && status_o[7] && !wp_n
    |=> !dec_accept && $stable(status_o[7:2])); // R6
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!por_n)
    fire && modify && since < LOCK_CYC |=> !dec_accept); // R7
  AST_WIP_BLOCK: assert property (@(posedge clk) disable iff (!por_n)
    fire && status_o[0] |=> !dec_accept); // R10
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    fire && !status_o[0] && modify && !status_o[1] |=> $stable(status_o)); // R8
endmodule

bind flash_guard flash_guard_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cnt_lo(cmd_clk_cnt[2:0]),
  .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_accept(dec_accept),
  .status_o(status_o)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  localparam int LOCK = 20;
  localparam int NV   = 36;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = '0;
  logic [23:0] cmd_addr = '0;
  logic [15:0] cmd_clk_cnt = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        dec_valid, dec_accept;
  logic        dec_ready = 1'b1;
  logic [7:0]  dec_opcode;
  logic        op_done = 1'b0;
  logic [7:0]  status_o;

  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flash_guard #(.LOCK_CYC(LOCK)) u_flash_guard (
    .clk(clk), .por_n(por_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_clk_cnt(cmd_clk_cnt), .cmd_wdata(cmd_wdata), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_accept(dec_accept), .dec_opcode(dec_opcode),
    .op_done(op_done), .status_o(status_o)
  );

  // op, addr, count, data, wp_n, accept, status, requirement
  // op 8'h00 marks an op_done pulse instead of a command
  localparam logic [69:0] VEC [0:NV-1] = '{
    {8'h02, 24'h000000, 16'd40, 8'h00, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 no latch
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h02, 4'd4},  // R4 set latch
    {8'h02, 24'h000000, 16'd41, 8'h00, 1'b1, 1'b0, 8'h02, 4'd3},  // R3 bad frame
    {8'h02, 24'h000000, 16'd40, 8'h00, 1'b1, 1'b1, 8'h03, 4'd10}, // R10 set wip
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b0, 8'h03, 4'd10}, // R10 busy
    {8'h00, 24'h000000, 16'd0,  8'h00, 1'b1, 1'b0, 8'h00, 4'd5},  // R5 done
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h02, 4'd4},
    {8'h04, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h00, 4'd5},  // R5 wrdi
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h02, 4'd4},
    {8'h01, 24'h000000, 16'd16, 8'h04, 1'b1, 1'b1, 8'h04, 4'd9},  // R9 level 1
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h06, 4'd4},
    {8'h02, 24'hFC0000, 16'd40, 8'h00, 1'b1, 1'b0, 8'h06, 4'd1},  // R1 sector 63
    {8'hD8, 24'hF80000, 16'd32, 8'h00, 1'b1, 1'b1, 8'h07, 4'd1},  // R1 sector 62
    {8'h00, 24'h000000, 16'd0,  8'h00, 1'b1, 1'b0, 8'h04, 4'd5},
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h06, 4'd4},
    {8'hC7, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b0, 8'h06, 4'd8},  // R8 R2 bulk blocked
    {8'h01, 24'h000000, 16'd16, 8'h98, 1'b1, 1'b1, 8'h98, 4'd9},  // R9 lock, level 6
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h9A, 4'd4},
    {8'hD8, 24'h800000, 16'd32, 8'h00, 1'b1, 1'b0, 8'h9A, 4'd1},  // R1 sector 32
    {8'hD8, 24'h7C0000, 16'd32, 8'h00, 1'b1, 1'b1, 8'h9B, 4'd1},  // R1 sector 31
    {8'h00, 24'h000000, 16'd0,  8'h00, 1'b1, 1'b0, 8'h98, 4'd5},
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h9A, 4'd4},
    {8'h01, 24'h000000, 16'd16, 8'h00, 1'b0, 1'b0, 8'h9A, 4'd6},  // R6 pin low
    {8'h01, 24'h000000, 16'd16, 8'h00, 1'b1, 1'b1, 8'h00, 4'd6},  // R6 pin high
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h02, 4'd4},
    {8'hC7, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h03, 4'd2},  // R2 level 0
    {8'h00, 24'h000000, 16'd0,  8'h00, 1'b1, 1'b0, 8'h00, 4'd5},
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h02, 4'd4},
    {8'h01, 24'h000000, 16'd16, 8'h1C, 1'b1, 1'b1, 8'h1C, 4'd1},  // R1 level 7
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h1E, 4'd4},
    {8'h02, 24'h000000, 16'd40, 8'h00, 1'b1, 1'b0, 8'h1E, 4'd1},  // R1 sector 0
    {8'h01, 24'h000000, 16'd15, 8'h00, 1'b1, 1'b0, 8'h1E, 4'd3},  // R3 status
    {8'h01, 24'h000000, 16'd16, 8'h6F, 1'b1, 1'b1, 8'h0C, 4'd9},  // R9 masked bits
    {8'h06, 24'h000000, 16'd8,  8'h00, 1'b1, 1'b1, 8'h0E, 4'd4},
    {8'h02, 24'hEC0000, 16'd40, 8'h00, 1'b1, 1'b1, 8'h0F, 4'd1},  // R1 sector 59
    {8'h00, 24'h000000, 16'd0,  8'h00, 1'b1, 1'b0, 8'h0C, 4'd5}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] ad,
                      input logic [15:0] cn, input logic [7:0] dt);
    @(negedge clk);
    cmd_opcode = op; cmd_addr = ad; cmd_clk_cnt = cn; cmd_wdata = dt;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    op_done = 1'b1;
    @(posedge clk);
    #1 op_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset status", {24'd0, status_o}, 32'h00);
    check("R11 reset dec_valid", {31'd0, dec_valid}, 32'd0);
    check("R11 reset cmd_ready", {31'd0, cmd_ready}, 32'd1);
    por_n = 1'b1;

    // R7 lockout: latch may be set, modifying commands refused
    send(8'h06, 24'h0, 16'd8, 8'h00);
    check("R7 wren during lockout", {31'd0, dec_accept}, 32'd1);
    send(8'h02, 24'h0, 16'd40, 8'h00);
    check("R7 program during lockout", {31'd0, dec_accept}, 32'd0);
    check("R7 status kept", {24'd0, status_o}, 32'h02);
    repeat (LOCK + 5) @(negedge clk);
    send(8'h04, 24'h0, 16'd8, 8'h00);
    check("R5 wrdi after lockout", {24'd0, status_o}, 32'h00);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      string tag;
      v = VEC[i];
      wp_n = v[13];
      tag = $sformatf("R%0d vector %0d", v[3:0], i);
      if (v[69:62] == 8'h00) pulse_done();
      else begin
        send(v[69:62], v[61:38], v[37:22], v[21:14]);
        check({tag, " accept"}, {31'd0, dec_accept}, {31'd0, v[12]});
        check({tag, " opcode"}, {24'd0, dec_opcode}, {24'd0, v[69:62]});
      end
      check({tag, " status"}, {24'd0, status_o}, {24'd0, v[11:4]});
    end
    wp_n = 1'b1;

    // R11 back-pressure
    @(negedge clk);
    dec_ready = 1'b0;
    send(8'h06, 24'h0, 16'd8, 8'h00);
    check("R11 first taken", {24'd0, status_o}, 32'h0E);
    @(negedge clk);
    cmd_opcode = 8'h04; cmd_clk_cnt = 16'd8; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 held valid", {31'd0, dec_valid}, 32'd1);
    check("R11 ready low", {31'd0, cmd_ready}, 32'd0);
    check("R11 second not taken", {24'd0, status_o}, 32'h0E);
    check("R11 decision stable", {24'd0, dec_opcode}, 32'h06);
    dec_ready = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    check("R11 second taken", {24'd0, status_o}, 32'h0C);
    check("R11 new decision", {24'd0, dec_opcode}, 32'h04);

    finish_run();
  end
endmodule